// File: doc/BRIEF.md
# DRAM Bank Command Timing Checker

This block watches the command stream that a memory controller sends to a DRAM device with four bank groups of four banks each. It judges every command as legal or illegal. A command is checked against the open or closed state of its target bank and against the minimum spacing, in clock cycles, since earlier commands. All spacing values are cycle counts on configuration inputs, so one build can serve any speed grade. The block issues no commands and moves no data. It only judges what it sees.

Each bank is modelled by a two-state machine. The states are `BANK_IDLE` (precharged, no row open) and `BANK_ACTIVE` (row open). Transition `IDLE->ACTIVE` happens on an accepted activate. Transition `ACTIVE->IDLE` happens on an accepted precharge. Each bank has saturating down-timers for the activate-to-column, activate-to-precharge, precharge-to-activate and activate-to-activate limits. A separate tracker enforces the activate-to-activate gap across banks. This gap is short when the two activates go to different bank groups and long when they go to the same group. An illegal command is dropped. One cycle later, the block raises a single-cycle error pulse with a 3-bit reason code.

Top module: `dram_cmd_checker`

## Requirements
- R1: After a synchronous reset (`rst` high), all banks are closed, every timer has expired and `err_valid` is low. A REF or an ACT to any bank is then legal at once.
- R2: A RD (op 1) or WR (op 2) to a closed bank is illegal with code 0.
- R3: A RD or WR to an open bank fewer than `cfg_trcd` cycles after its ACT is illegal with code 1.
- R4: A PRE (op 3) to an open bank fewer than `cfg_tras` cycles after its ACT is illegal with code 2. A PRE to a closed bank is legal and has no effect.
- R5: An ACT (op 0) to a closed bank fewer than `cfg_trp` cycles after its PRE is illegal with code 3.
- R6: An ACT to a bank fewer than `cfg_trc` cycles after that bank's previous ACT is illegal with code 4.
- R7: An ACT fewer than `cfg_trrd_s` cycles after the last accepted ACT, when that ACT was in a different bank group, is illegal with code 5.
- R8: An ACT fewer than `cfg_trrd_l` cycles after the last accepted ACT, when that ACT was in the same bank group, is illegal with code 6.
- R9: An ACT to an open bank is illegal with code 7. A REF (op 4) while any bank is open is illegal with code 7. A REF while all banks are closed but any bank is still inside its `cfg_trp` window is illegal with code 3.
- R10: The verdict is registered. `err_valid`/`err_code` reflect the command sampled at the previous clock edge. `err_valid` is low after cycles with no command or with a legal command.
- R11: An illegal command changes no bank state and no timer.
- R12: When several rules fail at once, one code is reported. For ACT the order is: open bank (7), then tRP (3), then tRC (4), then tRRD (6 or 5). For RD/WR the order is: closed bank (0), then tRCD (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 ACT, 1 RD, 2 WR, 3 PRE, 4 REF; other values ignored |
| cmd_bg | input | 2 | Target bank group |
| cmd_bank | input | 2 | Target bank within group |
| cfg_trcd | input | TW | ACT to RD/WR minimum, cycles |
| cfg_tras | input | TW | ACT to PRE minimum, cycles |
| cfg_trp | input | TW | PRE to ACT/REF minimum, cycles |
| cfg_trc | input | TW | ACT to ACT same bank minimum, cycles |
| cfg_trrd_s | input | TW | ACT to ACT, different group, cycles |
| cfg_trrd_l | input | TW | ACT to ACT, same group, cycles |
| err_valid | output | 1 | Single-cycle violation pulse |
| err_code | output | 3 | Reason code, valid with err_valid |

## Verification
Each spacing rule is tried at one cycle short of its limit and then exactly at the limit. This shows an off-by-one in the down-timers apart from a missing rule. Activate pairs are sent to the same group and to different groups, so a swap of the short and long gap shows up as a wrong code. Commands that fail several rules at once confirm the reported order. A read after a rejected activate shows that dropped commands leave the bank state alone.

// File: rtl/dram_chk_pkg.sv
package dram_chk_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_PRE = 3'd3,
        OP_REF = 3'd4
    } dram_op_e;

    typedef enum logic [2:0] {
        ERR_NO_ROW   = 3'd0,
        ERR_TRCD     = 3'd1,
        ERR_TRAS     = 3'd2,
        ERR_TRP      = 3'd3,
        ERR_TRC      = 3'd4,
        ERR_TRRD_S   = 3'd5,
        ERR_TRRD_L   = 3'd6,
        ERR_NOT_IDLE = 3'd7
    } err_code_e;

    typedef enum logic {
        BANK_IDLE   = 1'b0,
        BANK_ACTIVE = 1'b1
    } bank_state_e;

endpackage

// File: rtl/dram_down_timer.sv
module dram_down_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Loaded with N-1 so that a command k cycles later sees zero when k >= N.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (load_val == '0) ? '0 : load_val - TW'(1);
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dram_bank_fsm.sv
module dram_bank_fsm
    import dram_chk_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_go,
    input  logic          pre_go,
    input  logic [TW-1:0] cfg_trcd,
    input  logic [TW-1:0] cfg_tras,
    input  logic [TW-1:0] cfg_trp,
    input  logic [TW-1:0] cfg_trc,
    output logic          is_open,
    output logic          rcd_met,
    output logic          ras_met,
    output logic          rp_met,
    output logic          rc_met
);
    bank_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= BANK_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BANK_IDLE:   if (act_go) state_nx = BANK_ACTIVE;
            BANK_ACTIVE: if (pre_go) state_nx = BANK_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            BANK_IDLE:   is_open = 1'b0;
            BANK_ACTIVE: is_open = 1'b1;
        endcase
    end

    dram_down_timer #(.TW(TW)) u_rcd (.clk(clk), .rst(rst), .load(act_go), .load_val(cfg_trcd), .expired(rcd_met));
    dram_down_timer #(.TW(TW)) u_ras (.clk(clk), .rst(rst), .load(act_go), .load_val(cfg_tras), .expired(ras_met));
    dram_down_timer #(.TW(TW)) u_rc  (.clk(clk), .rst(rst), .load(act_go), .load_val(cfg_trc),  .expired(rc_met));
    dram_down_timer #(.TW(TW)) u_rp  (.clk(clk), .rst(rst), .load(pre_go), .load_val(cfg_trp),  .expired(rp_met));
endmodule

// File: rtl/dram_rrd_tracker.sv
module dram_rrd_tracker #(
    parameter int TW  = 6,
    parameter int BGW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           act_go,
    input  logic [BGW-1:0] act_bg,
    input  logic [BGW-1:0] query_bg,
    input  logic [TW-1:0]  cfg_trrd_s,
    input  logic [TW-1:0]  cfg_trrd_l,
    output logic           same_grp,
    output logic           s_met,
    output logic           l_met
);
    logic [BGW-1:0] last_bg;

    always_ff @(posedge clk) begin
        if (rst)         last_bg <= '0;
        else if (act_go) last_bg <= act_bg;
    end

    assign same_grp = (query_bg == last_bg);

    dram_down_timer #(.TW(TW)) u_short (.clk(clk), .rst(rst), .load(act_go), .load_val(cfg_trrd_s), .expired(s_met));
    dram_down_timer #(.TW(TW)) u_long  (.clk(clk), .rst(rst), .load(act_go), .load_val(cfg_trrd_l), .expired(l_met));
endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker
    import dram_chk_pkg::*;
#(
    parameter int TW         = 6,
    parameter int NUM_BG     = 4,
    parameter int BANK_PER_BG = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cmd_valid,
    input  logic [2:0]                     cmd_op,
    input  logic [$clog2(NUM_BG)-1:0]      cmd_bg,
    input  logic [$clog2(BANK_PER_BG)-1:0] cmd_bank,
    input  logic [TW-1:0]                  cfg_trcd,
    input  logic [TW-1:0]                  cfg_tras,
    input  logic [TW-1:0]                  cfg_trp,
    input  logic [TW-1:0]                  cfg_trc,
    input  logic [TW-1:0]                  cfg_trrd_s,
    input  logic [TW-1:0]                  cfg_trrd_l,
    output logic                           err_valid,
    output logic [2:0]                     err_code
);
    localparam int BGW   = $clog2(NUM_BG);
    localparam int BKW   = $clog2(BANK_PER_BG);
    localparam int NBANK = NUM_BG * BANK_PER_BG;
    localparam int IW    = BGW + BKW;

    logic [NBANK-1:0] bank_open, rcd_met, ras_met, rp_met, rc_met;
    logic [NBANK-1:0] act_go_v, pre_go_v;
    logic [IW-1:0]    idx;
    logic             same_grp, s_met, l_met;
    logic             bad, accept;
    err_code_e        code;

    assign idx = {cmd_bg, cmd_bank};

    always_comb begin
        bad  = 1'b0;
        code = ERR_NO_ROW;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ACT: begin
                    if (bank_open[idx])             begin bad = 1'b1; code = ERR_NOT_IDLE; end
                    else if (!rp_met[idx])          begin bad = 1'b1; code = ERR_TRP;      end
                    else if (!rc_met[idx])          begin bad = 1'b1; code = ERR_TRC;      end
                    else if (same_grp && !l_met)    begin bad = 1'b1; code = ERR_TRRD_L;   end
                    else if (!same_grp && !s_met)   begin bad = 1'b1; code = ERR_TRRD_S;   end
                end
                OP_RD, OP_WR: begin
                    if (!bank_open[idx])            begin bad = 1'b1; code = ERR_NO_ROW;   end
                    else if (!rcd_met[idx])         begin bad = 1'b1; code = ERR_TRCD;     end
                end
                OP_PRE: begin
                    if (bank_open[idx] && !ras_met[idx]) begin bad = 1'b1; code = ERR_TRAS; end
                end
                OP_REF: begin
                    if (|bank_open)                 begin bad = 1'b1; code = ERR_NOT_IDLE; end
                    else if (!(&rp_met))            begin bad = 1'b1; code = ERR_TRP;      end
                end
                default: ;
            endcase
        end
    end

    assign accept = cmd_valid && !bad;

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign act_go_v[i] = accept && (cmd_op == OP_ACT) && (idx == IW'(i));
        assign pre_go_v[i] = accept && (cmd_op == OP_PRE) && (idx == IW'(i)) && bank_open[i];

        dram_bank_fsm #(.TW(TW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act_go  (act_go_v[i]),
            .pre_go  (pre_go_v[i]),
            .cfg_trcd(cfg_trcd),
            .cfg_tras(cfg_tras),
            .cfg_trp (cfg_trp),
            .cfg_trc (cfg_trc),
            .is_open (bank_open[i]),
            .rcd_met (rcd_met[i]),
            .ras_met (ras_met[i]),
            .rp_met  (rp_met[i]),
            .rc_met  (rc_met[i])
        );
    end

    dram_rrd_tracker #(.TW(TW), .BGW(BGW)) u_rrd (
        .clk       (clk),
        .rst       (rst),
        .act_go    (|act_go_v),
        .act_bg    (cmd_bg),
        .query_bg  (cmd_bg),
        .cfg_trrd_s(cfg_trrd_s),
        .cfg_trrd_l(cfg_trrd_l),
        .same_grp  (same_grp),
        .s_met     (s_met),
        .l_met     (l_met)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= 3'd0;
        end else begin
            err_valid <= bad;
            err_code  <= bad ? code : 3'd0;
        end
    end
endmodule

// File: rtl/dram_cmd_checker_sva.sv
module dram_cmd_checker_sva #(
    parameter int IW    = 4,
    parameter int NBANK = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [IW-1:0]    cmd_idx,
    input logic             err_valid,
    input logic [2:0]       err_code,
    input logic [NBANK-1:0] bank_open
);
    assert_err_needs_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(cmd_valid));

    assert_col_closed_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) && !bank_open[cmd_idx])
        |=> (err_valid && err_code == 3'd0));

    assert_pre_closed_ok_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3 && !bank_open[cmd_idx]) |=> !err_valid);

    assert_act_open_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd0 && bank_open[cmd_idx])
        |=> (err_valid && err_code == 3'd7));

    assert_reject_no_change_R11: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (bank_open == $past(bank_open)));
endmodule

bind dram_cmd_checker dram_cmd_checker_sva #(.IW(IW), .NBANK(NBANK)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_idx  (idx),
    .err_valid(err_valid),
    .err_code (err_code),
    .bank_open(bank_open)
);

// File: tb/dram_cmd_checker_tb.sv
`timescale 1ns/1ps
module dram_cmd_checker_tb_top;
    import dram_chk_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bg = 2'd0, cmd_bank = 2'd0;
    logic [5:0] cfg_trcd = 6'd3, cfg_tras = 6'd5, cfg_trp = 6'd2;
    logic [5:0] cfg_trc = 6'd8, cfg_trrd_s = 6'd2, cfg_trrd_l = 6'd4;
    logic       err_valid;
    logic [2:0] err_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_cmd_checker dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bg(cmd_bg), .cmd_bank(cmd_bank),
        .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc), .cfg_trrd_s(cfg_trrd_s), .cfg_trrd_l(cfg_trrd_l),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic check_err(input bit exp_bad, input logic [2:0] exp_code, input string tag);
        checks++;
        if (err_valid !== exp_bad || (exp_bad && err_code !== exp_code)) begin
            failures++;
            $display("FAIL %s: err_valid=%0b code=%0d expected err_valid=%0b code=%0d",
                     tag, err_valid, err_code, exp_bad, exp_code);
        end
    endtask

    // Drives one command for one edge, then checks the registered verdict.
    task automatic send(input logic [2:0] op, input logic [1:0] bg, input logic [1:0] bk,
                        input bit exp_bad, input logic [2:0] exp_code, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_bg = bg; cmd_bank = bk;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        check_err(exp_bad, exp_code, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check_err(1'b0, 3'd0, "R1 reset err_valid low");
        send(OP_REF, 2'd0, 2'd0, 1'b0, 3'd0, "R1 REF legal after reset");
        send(OP_RD, 2'd0, 2'd0, 1'b1, 3'd0, "R2 RD to closed bank");
        send(OP_PRE, 2'd0, 2'd2, 1'b0, 3'd0, "R4 PRE to closed bank no-op");
        idle(1);
        check_err(1'b0, 3'd0, "R10 no command no error");
    endtask

    task automatic t_single_bank;
        send(OP_ACT, 2'd0, 2'd0, 1'b0, 3'd0, "R1 ACT legal after reset");     // e0
        idle(1);                                                               // e1
        send(OP_RD, 2'd0, 2'd0, 1'b1, 3'd1, "R3 RD at gap 2");                 // e2
        send(OP_RD, 2'd0, 2'd0, 1'b0, 3'd0, "R3 RD at gap 3");                 // e3
        send(OP_PRE, 2'd0, 2'd0, 1'b1, 3'd2, "R4 PRE at gap 4");               // e4
        send(OP_PRE, 2'd0, 2'd0, 1'b0, 3'd0, "R4 PRE at gap 5");               // e5
        send(OP_ACT, 2'd0, 2'd0, 1'b1, 3'd3, "R12 R5 ACT with tRP and tRC pending"); // e6
        send(OP_ACT, 2'd0, 2'd0, 1'b1, 3'd4, "R6 ACT at tRC gap 7");           // e7
        send(OP_ACT, 2'd0, 2'd0, 1'b0, 3'd0, "R6 ACT at tRC gap 8");           // e8
        send(OP_ACT, 2'd0, 2'd0, 1'b1, 3'd7, "R9 ACT to open bank");           // e9
        send(OP_REF, 2'd0, 2'd0, 1'b1, 3'd7, "R9 REF with open bank");         // e10
        send(OP_WR, 2'd0, 2'd0, 1'b0, 3'd0, "R3 WR after tRCD");               // e11
        idle(1);                                                               // e12
        send(OP_PRE, 2'd0, 2'd0, 1'b0, 3'd0, "R4 PRE at gap 5 again");         // e13
        send(OP_REF, 2'd0, 2'd0, 1'b1, 3'd3, "R9 REF inside tRP");             // e14
        send(OP_REF, 2'd0, 2'd0, 1'b0, 3'd0, "R9 REF after tRP");              // e15
    endtask

    task automatic t_group_spacing;
        send(OP_ACT, 2'd1, 2'd0, 1'b0, 3'd0, "R8 first ACT bg1");              // f0
        idle(1);
        send(OP_ACT, 2'd1, 2'd1, 1'b1, 3'd6, "R8 same group gap 2");           // f0+2
        send(OP_ACT, 2'd2, 2'd0, 1'b0, 3'd0, "R7 other group gap 3");          // f0+3
        send(OP_ACT, 2'd3, 2'd0, 1'b1, 3'd5, "R7 other group gap 1");          // f0+4
        send(OP_ACT, 2'd3, 2'd0, 1'b0, 3'd0, "R7 other group gap 2");          // f0+5
        idle(3);
        send(OP_ACT, 2'd3, 2'd1, 1'b0, 3'd0, "R8 same group gap 4");
        send(OP_RD, 2'd1, 2'd1, 1'b1, 3'd0, "R11 rejected ACT left bank closed");
        send(OP_WR, 2'd1, 2'd0, 1'b0, 3'd0, "R3 WR to bank opened earlier");
        idle(1);
        check_err(1'b0, 3'd0, "R10 pulse lasts one cycle");
    endtask

    initial begin
        #1;
        idle(1);
        t_reset();
        t_single_bank();
        t_group_spacing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule